// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Controller

This block watches 23 asynchronous request lines and turns chosen transitions on them into interrupt or event notifications. Lines 0 to 15 each pick their input from the same-numbered pin of one of several 16-bit GPIO ports. Lines 16 to 22 are wired to internal event sources. Each input goes through a two-stage synchronizer. An edge detector then compares the synchronized level with the level one cycle earlier.

Each line has its own rising-edge and falling-edge enables, its own interrupt mask and its own event mask. A qualifying edge does one of two things. On a line routed to events it produces a one-cycle pulse. Otherwise it sets a sticky pending flag, which software clears by writing a one to it. The interrupt request of a line is its pending flag gated by its interrupt mask. All configuration and the pending flags sit behind a small single-cycle register bus with combinational read data.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, every register reads 0, and `irq_o` and `evt_o` are 0.
- R2: A change on a selected input is seen at the edge detector two clock edges after it settles. The resulting pending bit or event pulse is registered on the third rising edge.
- R3: Two enables control the edges that trigger line x. Rising-enable register bit x enables 0→1 edges. Falling-enable register bit x enables 1→0 edges. With both set, any edge triggers the line. With neither set, the line never triggers.
- R4: Pending bits are sticky. A bus write to address 4 clears every pending bit whose write-data bit is 1, and data bits of 0 have no effect. When a triggering edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R5: If event-mask bit x (address 1) is 1, a triggering edge on line x gives a one-cycle high pulse on `evt_o[x]` and leaves pending bit x unchanged.
- R6: `irq_o[x]` is 1 exactly when pending bit x is 1 and interrupt-mask bit x (address 0) is 1. Clearing the mask hides the request without clearing the pending bit.
- R7: Line x (0 to 15) has a 4-bit port-select field. It sits at bits [4*(x%8)+3 : 4*(x%8)] of address 5 for x < 8 and of address 6 otherwise. Select value p below NUM_PORTS routes `gpio_i[16*p+x]` to the line. Larger values route a constant 0. Changing the select is itself a level change seen by the edge detector.
- R8: Line 16+k takes `int_src_i[k]` as its input.
- R9: The register map is: address 0 interrupt mask, 1 event mask, 2 rising enable, 3 falling enable, 4 pending, 5 and 6 port select. Bits above bit 22 of addresses 0 to 4 read 0, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | 144 | Port p pin x at bit 16*p+x, asynchronous |
| int_src_i | input | 7 | Internal event sources for lines 16 to 22, asynchronous |
| bus_wen_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 23 | Per-line interrupt request |
| evt_o | output | 23 | Per-line one-cycle event pulse |

## Verification
The hardest case to reach is the collision between a clear and a new edge on the same pending bit. The clear write has to land in the exact cycle in which the synchronized edge is detected, three rising edges after the pin moves. A directed sequence first leaves the bit set and then drives the pin. It counts two falling clock edges and asserts the clear strobe so that it covers only the third rising edge. A long random phase then mixes pin toggles, select rewrites and clear writes. This hits the collision and the select-induced edges many more times, and a behavioural model judges every cycle.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_IMASK = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_EMASK = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_RISE  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FALL  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_PEND  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_SEL0  = 3'd5;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/edge_irq_portmux.sv
module edge_irq_portmux #(
    parameter int NUM_PINS  = 16,
    parameter int NUM_PORTS = 9,
    parameter int SEL_W     = 4
) (
    input  logic [NUM_PORTS*NUM_PINS-1:0] gpio_i,
    input  logic [NUM_PINS*SEL_W-1:0]     sel_i,
    output logic [NUM_PINS-1:0]           line_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic pick_v;
        always_comb begin
            pick_v = 1'b0;
            for (int k = 0; k < NUM_PORTS; k++) begin
                if (sel_i[p*SEL_W +: SEL_W] == SEL_W'(k))
                    pick_v = gpio_i[k*NUM_PINS + p];
            end
        end
        assign line_o[p] = pick_v;
    end
endmodule

// File: rtl/edge_irq_edge.sv
module edge_irq_edge #(
    parameter int W = 23
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] trig_o
);
    logic [W-1:0] up_v, down_v;

    always_comb begin
        up_v   = cur_i & ~prev_i;
        down_v = ~cur_i & prev_i;
        trig_o = (up_v & rise_en_i) | (down_v & fall_en_i);
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 23,
    parameter int NUM_PINS  = 16,
    parameter int NUM_PORTS = 9,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*NUM_PINS-1:0] gpio_i,
    input  logic [NUM_LINES-NUM_PINS-1:0] int_src_i,
    input  logic                          bus_wen_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    output logic [NUM_LINES-1:0]          irq_o,
    output logic [NUM_LINES-1:0]          evt_o
);
    localparam int N         = NUM_LINES;
    localparam int SEL_BITS  = NUM_PINS * SEL_W;
    localparam int SEL_WORDS = (SEL_BITS + DATA_W - 1) / DATA_W;
    localparam int SEL_REG_W = SEL_WORDS * DATA_W;

    typedef struct packed {
        logic [N-1:0]         imask;
        logic [N-1:0]         emask;
        logic [N-1:0]         rise;
        logic [N-1:0]         fall;
        logic [N-1:0]         pend;
        logic [N-1:0]         evt;
        logic [N-1:0]         prev;
        logic [SEL_REG_W-1:0] sel;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [NUM_PINS-1:0] pin_line;
    logic [N-1:0]        raw_line;
    logic [N-1:0]        sync_line;
    logic [N-1:0]        trig;
    logic [N-1:0]        clr_mask;

    // vectors exposed for the bound checker
    logic [N-1:0] pend_vec, emask_vec, rise_vec, fall_vec;

    edge_irq_portmux #(
        .NUM_PINS (NUM_PINS),
        .NUM_PORTS(NUM_PORTS),
        .SEL_W    (SEL_W)
    ) u_mux (
        .gpio_i(gpio_i),
        .sel_i (st_q.sel[SEL_BITS-1:0]),
        .line_o(pin_line)
    );

    assign raw_line = {int_src_i, pin_line};

    edge_irq_sync #(.W(N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_line),
        .q_o  (sync_line)
    );

    edge_irq_edge #(.W(N)) u_edge (
        .cur_i    (sync_line),
        .prev_i   (st_q.prev),
        .rise_en_i(st_q.rise),
        .fall_en_i(st_q.fall),
        .trig_o   (trig)
    );

    always_comb begin
        st_d      = st_q;
        clr_mask  = '0;
        st_d.prev = sync_line;
        st_d.evt  = trig & st_q.emask;

        if (bus_wen_i) begin
            case (bus_addr_i)
                ADDR_IMASK: st_d.imask = bus_wdata_i[N-1:0];
                ADDR_EMASK: st_d.emask = bus_wdata_i[N-1:0];
                ADDR_RISE:  st_d.rise  = bus_wdata_i[N-1:0];
                ADDR_FALL:  st_d.fall  = bus_wdata_i[N-1:0];
                ADDR_PEND:  clr_mask   = bus_wdata_i[N-1:0];
                default: begin
                    for (int w = 0; w < SEL_WORDS; w++) begin
                        if (bus_addr_i == ADDR_W'(int'(ADDR_SEL0) + w))
                            st_d.sel[w*DATA_W +: DATA_W] = bus_wdata_i;
                    end
                end
            endcase
        end

        // a new edge wins over a clear of the same bit
        st_d.pend = (st_q.pend & ~clr_mask) | (trig & ~st_q.emask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_IMASK: bus_rdata_o = {{(DATA_W-N){1'b0}}, st_q.imask};
            ADDR_EMASK: bus_rdata_o = {{(DATA_W-N){1'b0}}, st_q.emask};
            ADDR_RISE:  bus_rdata_o = {{(DATA_W-N){1'b0}}, st_q.rise};
            ADDR_FALL:  bus_rdata_o = {{(DATA_W-N){1'b0}}, st_q.fall};
            ADDR_PEND:  bus_rdata_o = {{(DATA_W-N){1'b0}}, st_q.pend};
            default: begin
                for (int w = 0; w < SEL_WORDS; w++) begin
                    if (bus_addr_i == ADDR_W'(int'(ADDR_SEL0) + w))
                        bus_rdata_o = st_q.sel[w*DATA_W +: DATA_W];
                end
            end
        endcase
    end

    assign irq_o     = st_q.pend & st_q.imask;
    assign evt_o     = st_q.evt;
    assign pend_vec  = st_q.pend;
    assign emask_vec = st_q.emask;
    assign rise_vec  = st_q.rise;
    assign fall_vec  = st_q.fall;
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
    parameter int N = 23
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wen_i,
    input logic [2:0]   bus_addr_i,
    input logic [N-1:0] evt_o,
    input logic [N-1:0] pend,
    input logic [N-1:0] emask,
    input logic [N-1:0] rise,
    input logic [N-1:0] fall
);
    // R1: nothing pending or pulsing on the first cycle out of reset
    a_r1_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (evt_o == '0 && pend == '0));

    // R4: without a clear write, no pending bit can drop
    a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen_i && bus_addr_i == 3'd4) |=> ((pend & $past(pend)) == $past(pend)));

    // R5: pulses only on event-routed lines
    a_r5_evt_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != '0) |-> ((evt_o & ~$past(emask)) == '0));

    // R5: event-routed lines never set a pending bit
    a_r5_evt_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & ~$past(pend) & $past(emask)) == '0));

    // R3: a line with no edge enabled never becomes pending
    a_r3_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & ~$past(pend) & ~($past(rise) | $past(fall))) == '0));
endmodule

bind edge_irq_ctrl edge_irq_chk #(.N(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen_i (bus_wen_i),
    .bus_addr_i(bus_addr_i),
    .evt_o     (evt_o),
    .pend      (pend_vec),
    .emask     (emask_vec),
    .rise      (rise_vec),
    .fall      (fall_vec)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
    localparam int NL = 23;
    localparam int NP = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [143:0] gpio = '0;
    logic [6:0]  isrc = '0;
    logic        wen = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [22:0] irq, evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    always #5 clk = ~clk;

    edge_irq_ctrl u_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .int_src_i(isrc),
        .bus_wen_i(wen), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .evt_o(evt)
    );

    // ---------------- behavioural reference ----------------
    logic [22:0] m_im, m_em, m_ri, m_fa, m_pe, m_ev, m_s1, m_s2, m_pv;
    logic [63:0] m_sel;

    function automatic logic [22:0] line_levels();
        logic [22:0] r;
        for (int x = 0; x < 16; x++) begin
            int p = int'(m_sel[x*4 +: 4]);
            r[x] = (p < NP) ? gpio[p*16 + x] : 1'b0;
        end
        for (int k = 0; k < 7; k++) r[16+k] = isrc[k];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {9'd0, m_im};
            3'd1: return {9'd0, m_em};
            3'd2: return {9'd0, m_ri};
            3'd3: return {9'd0, m_fa};
            3'd4: return {9'd0, m_pe};
            3'd5: return m_sel[31:0];
            3'd6: return m_sel[63:32];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_im = '0; m_em = '0; m_ri = '0; m_fa = '0; m_pe = '0;
            m_ev = '0; m_s1 = '0; m_s2 = '0; m_pv = '0; m_sel = '0;
        end else begin
            logic [22:0] hit, clr;
            hit = '0;
            for (int x = 0; x < NL; x++) begin
                if (m_s2[x] && !m_pv[x] && m_ri[x]) hit[x] = 1'b1;
                if (!m_s2[x] && m_pv[x] && m_fa[x]) hit[x] = 1'b1;
            end
            clr  = (wen && addr == 3'd4) ? wdata[22:0] : 23'd0;
            m_ev = hit & m_em;
            m_pe = (m_pe & ~clr) | (hit & ~m_em);
            m_pv = m_s2;
            m_s2 = m_s1;
            m_s1 = line_levels();
            if (wen) begin
                case (addr)
                    3'd0: m_im = wdata[22:0];
                    3'd1: m_em = wdata[22:0];
                    3'd2: m_ri = wdata[22:0];
                    3'd3: m_fa = wdata[22:0];
                    3'd5: m_sel[31:0]  = wdata;
                    3'd6: m_sel[63:32] = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            check("R6 irq", {9'd0, irq}, {9'd0, m_pe & m_im});
            check("R5 evt", {9'd0, evt}, {9'd0, m_ev});
            check("R9 rdata", rdata, m_read(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        addr = a;
        #1 d = rdata;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int pulses;
        repeat (3) @(negedge clk);
        // R1: values during reset
        check("R1 irq in reset", {9'd0, irq}, 32'd0);
        check("R1 evt in reset", {9'd0, evt}, 32'd0);
        #1 rst_n = 1'b1;
        live = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg reset", v, 32'd0);
        end

        // R2/R3: rising enable on line 0, port 0, latency
        wr(3'd2, 32'h1);
        wr(3'd0, 32'h1);
        @(negedge clk); #1;
        addr = 3'd4;
        gpio[0] = 1'b1;
        tick(1); tick(1);
        check("R2 not yet pending", rdata, 32'd0);
        tick(1);
        check("R2 pending on third edge", rdata, 32'h1);
        check("R6 irq follows pending", {9'd0, irq}, 32'h1);

        // R4: write 0 no effect, write 1 clears
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        check("R4 zero write keeps bit", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        check("R4 one write clears", v, 32'h0);

        // R3: falling not selected on line 0
        gpio[0] = 1'b0;
        tick(5);
        rd(3'd4, v);
        check("R3 disabled edge ignored", v, 32'h0);

        // R7/R3: line 3 on port 2, falling only
        wr(3'd3, 32'h8);
        wr(3'd5, 32'h0000_2000);
        gpio[2*16+3] = 1'b1;
        tick(5);
        rd(3'd4, v);
        check("R3 rising ignored on fall-only", v, 32'h0);
        gpio[2*16+3] = 1'b0;
        tick(5);
        rd(3'd4, v);
        check("R7 port 2 fall sets bit3", v, 32'h8);
        // R6: mask off for line 3 keeps pending hidden
        check("R6 masked irq low", {9'd0, irq}, 32'h0);

        // R3: both edges on line 5
        wr(3'd4, 32'h8);
        wr(3'd2, 32'h21);
        wr(3'd3, 32'h28);
        gpio[5] = 1'b1;
        tick(5);
        rd(3'd4, v);
        check("R3 both: rise", v, 32'h20);
        wr(3'd4, 32'h20);
        gpio[5] = 1'b0;
        tick(5);
        rd(3'd4, v);
        check("R3 both: fall", v, 32'h20);
        wr(3'd4, 32'h20);

        // R5: event routing on line 7
        wr(3'd1, 32'h80);
        wr(3'd2, 32'h81);
        gpio[7] = 1'b1;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (evt[7]) pulses++;
        end
        check("R5 single pulse", 32'(pulses), 32'd1);
        rd(3'd4, v);
        check("R5 no pending", v, 32'h0);

        // R7: out-of-range select gives 0, valid select picks pin
        wr(3'd2, 32'h201);
        wr(3'd6, 32'h0000_00F0);
        for (int p = 0; p < NP; p++) gpio[p*16+9] = 1'b1;
        tick(5);
        rd(3'd4, v);
        check("R7 invalid select is 0", v, 32'h0);
        wr(3'd6, 32'h0000_0080);
        tick(5);
        rd(3'd4, v);
        check("R7 port 8 select", v, 32'h200);
        wr(3'd4, 32'h200);

        // R8: internal source line 18
        wr(3'd2, 32'h40001);
        isrc[2] = 1'b1;
        tick(5);
        rd(3'd4, v);
        check("R8 internal line 18", v, 32'h40000);
        wr(3'd4, 32'h40000);

        // R4: clear collides with a new edge on line 0
        gpio[0] = 1'b1;
        tick(5);
        gpio[0] = 1'b0;
        tick(4);
        rd(3'd4, v);
        check("R4 bit0 set before collision", v, 32'h1);
        gpio[0] = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        wen = 1'b1; addr = 3'd4; wdata = 32'h1;
        @(negedge clk); #1;
        wen = 1'b0;
        rd(3'd4, v);
        check("R4 edge wins over clear", v, 32'h1);

        // R9: unused bits and address
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v);
        check("R9 upper bits read 0", v, 32'h007F_FFFF);
        rd(3'd7, v);
        check("R9 address 7 reads 0", v, 32'h0);

        // random mix judged by the model each cycle
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk); #1;
            if ($urandom_range(0, 3) == 0) gpio[$urandom_range(0, 143)] ^= 1'b1;
            if ($urandom_range(0, 7) == 0) isrc[$urandom_range(0, 6)] ^= 1'b1;
            addr = 3'($urandom_range(0, 7));
            wen  = ($urandom_range(0, 5) == 0);
            wdata = $urandom;
            if (addr == 3'd5 || addr == 3'd6) wdata = wdata & 32'h7777_7777;
            if (addr == 3'd1) wdata = wdata & 32'h0000_FF00;
        end
        @(negedge clk); #1;
        wen = 1'b0;
        tick(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule